// File: doc/BRIEF.md
# External Data Move Prediction Gate

This block sits beside the multiplexed address/data bus of an 8-bit microcontroller that has no wait states. When that controller reads or writes external data, the shared memory behind the bus must answer within a fixed strobe width. The strobe cannot be stretched, so any other master, such as a DMA engine, has to be kept off the memory before the strobe arrives. The gate watches every instruction fetch. When the fetched opcode is one of the external data move instructions, it lowers a DMA-permit output so that the memory is idle when the controller's read or write strobe comes.

All bus strobes are asynchronous to the local clock, so each one passes through a synchronizer chain. The data byte is delayed by the same number of stages so that it stays aligned with the fetch strobe. A fetch only counts if the address-latch strobe was seen since the previous fetch ended. After a prediction, the permit stays low while the expected strobe is active and comes back one cycle after the strobe is released. Sometimes the predicted move never happens, for example when the matching byte was an operand and not an opcode. In that case a 31-cycle timer restores the permit on its own. Another matching fetch restarts that timer.

Top module: `xmg_gate`

## Requirements
- R1: After reset `dma_ok_o` is 1, and it stays 1 while no prediction is pending.
- R2: A fetch counts as a prediction only when the byte on `bus_data_i` at the end of the fetch is 0xE0, 0xE2, 0xE3, 0xF0, 0xF2 or 0xF3. Any other byte (for example 0xE1, 0xF1, 0xE4 or 0x00) leaves `dma_ok_o` at 1.
- R3: The end of a fetch is the rising edge of `psen_n_i`. Counting the first clock edge that samples `psen_n_i` high as edge 1, a matching fetch makes `dma_ok_o` 0 right after edge 3. The data byte must be valid at edge 1.
- R4: If neither `rd_n_i` nor `wr_n_i` goes low after a prediction, `dma_ok_o` stays 0 for exactly 31 clock cycles and then returns to 1.
- R5: Once a prediction is pending, a low level on `rd_n_i` or `wr_n_i` keeps `dma_ok_o` at 0 for as long as the strobe is low. Counting the first edge that samples the released strobe high as edge 1, `dma_ok_o` returns to 1 right after edge 3. The timer does not apply while the strobe is held.
- R6: A matching fetch that ends while the timer is running restarts the 31-cycle count.
- R7: A matching fetch is ignored unless `ale_i` has been sampled high since the previous fetch ended.
- R8: A read or write strobe while no prediction is pending has no effect, and `dma_ok_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ale_i | input | 1 | Address-latch strobe, active high, asynchronous |
| psen_n_i | input | 1 | Program-fetch strobe, active low, asynchronous |
| rd_n_i | input | 1 | External data read strobe, active low, asynchronous |
| wr_n_i | input | 1 | External data write strobe, active low, asynchronous |
| bus_data_i | input | 8 | Multiplexed data bus carrying the fetched opcode |
| dma_ok_o | output | 1 | DMA permit, 1 when no external data move is expected |

## Verification
The bench fetches each of the six move opcodes and several near misses (0xE1, 0xF1, 0xE4, 0x00). This separates a correct opcode decode from one that is too loose or too strict. Matching fetches are then followed by a read strobe, by a write strobe and by no strobe at all, which separates the strobe-driven release from the 31-cycle timeout. Two further patterns each tell a specific fault apart. A second matching fetch part way through the timeout shows whether the count restarts. A fetch without a preceding address-latch pulse, and a strobe with nothing predicted, show whether the gate reacts to events it must ignore.

// File: rtl/xmg_pkg.sv
package xmg_pkg;

    localparam int OP_W = 8;

    typedef enum logic [1:0] {
        GATE_IDLE  = 2'd0,
        GATE_ARMED = 2'd1,
        GATE_XFER  = 2'd2
    } gate_state_e;

    // External data move opcodes: 111x_00yz with yz != 01
    function automatic logic is_ext_move(input logic [OP_W-1:0] op);
        return (op[7:5] == 3'b111) && (op[3:2] == 2'b00) && (op[1:0] != 2'b01);
    endfunction

endpackage

// File: rtl/xmg_sync.sv
module xmg_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = async_i;
        end else begin : g_chain
            always_comb chain_d = {chain_q[STAGES-2:0], async_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/xmg_bus_capture.sv
module xmg_bus_capture
    import xmg_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ale_i,
    input  logic            psen_n_i,
    input  logic            rd_n_i,
    input  logic            wr_n_i,
    input  logic [OP_W-1:0] data_i,
    output logic            ale_s,
    output logic            psen_n_s,
    output logic            rd_n_s,
    output logic            wr_n_s,
    output logic [OP_W-1:0] data_s
);

    localparam int         NSTROBE    = 4;
    // bit 0 address latch (idle low), bits 1..3 active-low strobes (idle high)
    localparam logic [3:0] STROBE_RST = 4'b1110;

    logic [NSTROBE-1:0] raw_vec;
    logic [NSTROBE-1:0] sync_vec;

    assign raw_vec = {wr_n_i, rd_n_i, psen_n_i, ale_i};

    generate
        for (genvar g = 0; g < NSTROBE; g++) begin : g_strobe
            xmg_sync #(
                .STAGES  (STAGES),
                .RST_VAL (STROBE_RST[g])
            ) i_sync (
                .clk     (clk),
                .rst_n   (rst_n),
                .async_i (raw_vec[g]),
                .sync_o  (sync_vec[g])
            );
        end
    endgenerate

    assign ale_s    = sync_vec[0];
    assign psen_n_s = sync_vec[1];
    assign rd_n_s   = sync_vec[2];
    assign wr_n_s   = sync_vec[3];

    // Data delayed by the same depth so it stays aligned with the fetch strobe
    logic [OP_W-1:0] dpipe_d [STAGES];
    logic [OP_W-1:0] dpipe_q [STAGES];

    always_comb begin
        dpipe_d[0] = data_i;
        for (int i = 1; i < STAGES; i++) dpipe_d[i] = dpipe_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) dpipe_q[i] <= '0;
        end else begin
            for (int i = 0; i < STAGES; i++) dpipe_q[i] <= dpipe_d[i];
        end
    end

    assign data_s = dpipe_q[STAGES-1];

endmodule

// File: rtl/xmg_fetch_detect.sv
module xmg_fetch_detect
    import xmg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ale_s,
    input  logic            psen_n_s,
    input  logic [OP_W-1:0] data_s,
    output logic            fetch_hit
);

    typedef struct packed {
        logic psen_prev;
        logic ale_seen;
    } det_t;

    det_t det_d, det_q;
    logic fetch_end;

    always_comb begin
        det_d     = det_q;
        fetch_end = psen_n_s && !det_q.psen_prev;
        fetch_hit = fetch_end && det_q.ale_seen && is_ext_move(data_s);
        det_d.psen_prev = psen_n_s;
        if (fetch_end)  det_d.ale_seen = 1'b0;
        else if (ale_s) det_d.ale_seen = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) det_q <= '{psen_prev: 1'b1, ale_seen: 1'b0};
        else        det_q <= det_d;
    end

    AST_HIT_IS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_hit |=> !fetch_hit);                                        // R3
    AST_FETCH_CONSUMES_ALE: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_end && !ale_s) |=> !det_q.ale_seen);                       // R7

endmodule

// File: rtl/xmg_permit_fsm.sv
module xmg_permit_fsm
    import xmg_pkg::*;
#(
    parameter int TIMEOUT = 31
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fetch_hit,
    input  logic rd_n_s,
    input  logic wr_n_s,
    output logic dma_ok
);

    localparam int            CW   = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

    typedef struct packed {
        gate_state_e   st;
        logic [CW-1:0] cnt;
        logic          ok;
    } fsm_t;

    localparam fsm_t FSM_RST = '{st: GATE_IDLE, cnt: '0, ok: 1'b1};

    fsm_t fsm_d, fsm_q;
    logic strobe;

    always_comb begin
        fsm_d  = fsm_q;
        strobe = !rd_n_s || !wr_n_s;
        unique case (fsm_q.st)
            GATE_IDLE: begin
                if (fetch_hit) begin
                    fsm_d.st  = GATE_ARMED;
                    fsm_d.cnt = '0;
                    fsm_d.ok  = 1'b0;
                end
            end
            GATE_ARMED: begin
                if (strobe) begin
                    fsm_d.st  = GATE_XFER;
                    fsm_d.cnt = '0;
                end else if (fetch_hit) begin
                    fsm_d.cnt = '0;
                end else if (fsm_q.cnt == LAST) begin
                    fsm_d.st  = GATE_IDLE;
                    fsm_d.cnt = '0;
                    fsm_d.ok  = 1'b1;
                end else begin
                    fsm_d.cnt = fsm_q.cnt + 1'b1;
                end
            end
            GATE_XFER: begin
                if (!strobe) begin
                    fsm_d.st = GATE_IDLE;
                    fsm_d.ok = 1'b1;
                end
            end
            default: fsm_d = FSM_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= FSM_RST;
        else        fsm_q <= fsm_d;
    end

    assign dma_ok = fsm_q.ok;

    AST_DROP_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == GATE_IDLE && fetch_hit) |=> !dma_ok);                // R2
    AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_q.cnt <= LAST);                                               // R4
    AST_HOLD_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st != GATE_IDLE && strobe) |=> !dma_ok);                   // R5
    AST_RELEASE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == GATE_XFER && !strobe) |=> dma_ok);                   // R5
    AST_RESTART_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == GATE_ARMED && fetch_hit && !strobe) |=> (fsm_q.cnt == '0)); // R6

endmodule

// File: rtl/xmg_gate.sv
module xmg_gate
    import xmg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int TIMEOUT     = 31
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ale_i,
    input  logic            psen_n_i,
    input  logic            rd_n_i,
    input  logic            wr_n_i,
    input  logic [OP_W-1:0] bus_data_i,
    output logic            dma_ok_o
);

    logic            ale_s;
    logic            psen_n_s;
    logic            rd_n_s;
    logic            wr_n_s;
    logic [OP_W-1:0] data_s;
    logic            fetch_hit;

    xmg_bus_capture #(.STAGES(SYNC_STAGES)) i_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .ale_i    (ale_i),
        .psen_n_i (psen_n_i),
        .rd_n_i   (rd_n_i),
        .wr_n_i   (wr_n_i),
        .data_i   (bus_data_i),
        .ale_s    (ale_s),
        .psen_n_s (psen_n_s),
        .rd_n_s   (rd_n_s),
        .wr_n_s   (wr_n_s),
        .data_s   (data_s)
    );

    xmg_fetch_detect i_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .ale_s     (ale_s),
        .psen_n_s  (psen_n_s),
        .data_s    (data_s),
        .fetch_hit (fetch_hit)
    );

    xmg_permit_fsm #(.TIMEOUT(TIMEOUT)) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .fetch_hit (fetch_hit),
        .rd_n_s    (rd_n_s),
        .wr_n_s    (wr_n_s),
        .dma_ok    (dma_ok_o)
    );

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_ok_o && !fetch_hit) |=> dma_ok_o);                           // R8

endmodule

// File: tb/test_xmg_gate.sv
`timescale 1ns/1ps
module test_xmg_gate;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ale = 1'b0;
    logic       psen_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [7:0] bdata = 8'h00;
    logic       dma_ok;

    always #2 clk = ~clk;

    xmg_gate i_xmg_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .ale_i      (ale),
        .psen_n_i   (psen_n),
        .rd_n_i     (rd_n),
        .wr_n_i     (wr_n),
        .bus_data_i (bdata),
        .dma_ok_o   (dma_ok)
    );

    int    compared = 0;
    int    mismatched = 0;
    int    cycles = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // ---------------- behavioural reference ----------------
    typedef struct { bit ale; bit psen_n; bit rd_n; bit wr_n; int data; } smp_t;
    smp_t hist[$];
    int   m_mode;      // 0 nothing pending, 1 waiting for strobe, 2 strobe active
    int   m_age;
    bit   m_ale_seen;
    bit   m_ok;

    function automatic bit is_move(int op);
        return op == 'hE0 || op == 'hE2 || op == 'hE3 ||
               op == 'hF0 || op == 'hF2 || op == 'hF3;
    endfunction

    task automatic model_reset();
        smp_t idle;
        idle.ale = 0; idle.psen_n = 1; idle.rd_n = 1; idle.wr_n = 1; idle.data = 0;
        hist.delete();
        repeat (4) hist.push_back(idle);
        m_mode = 0; m_age = 0; m_ale_seen = 0; m_ok = 1;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            smp_t s;
            bit   fend, hit, stb;
            s.ale = ale; s.psen_n = psen_n; s.rd_n = rd_n; s.wr_n = wr_n; s.data = bdata;
            hist.push_back(s);
            void'(hist.pop_front());
            // two-cycle view after synchronisation
            fend = hist[1].psen_n && !hist[0].psen_n;
            hit  = fend && m_ale_seen && is_move(hist[1].data);
            stb  = !hist[1].rd_n || !hist[1].wr_n;
            case (m_mode)
                0: if (hit) begin m_mode = 1; m_age = 0; m_ok = 0; end
                1: begin
                    if (stb) m_mode = 2;
                    else if (hit) m_age = 0;
                    else if (m_age == 30) begin m_mode = 0; m_ok = 1; end
                    else m_age++;
                end
                default: if (!stb) begin m_mode = 0; m_ok = 1; end
            endcase
            if (fend) m_ale_seen = 0;
            else if (hist[1].ale) m_ale_seen = 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            compared++;
            if (dma_ok !== m_ok) begin
                mismatched++;
                $display("FAIL %s: dma_ok=%0b expected %0b at cycle %0d",
                         cur_req, dma_ok, m_ok, cycles);
            end
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cycles++;
        if (cycles == 100000 && !done) begin
            mismatched++;
            $display("FAIL watchdog: run did not end, cycles=%0d expected below 100000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spot(bit exp, string req);
        compared++;
        if (dma_ok !== exp) begin
            mismatched++;
            $display("FAIL %s: dma_ok=%0b expected %0b (spot)", req, dma_ok, exp);
        end
    endtask

    task automatic fetch(int op, bit with_ale);
        if (with_ale) begin ale = 1; tick(2); ale = 0; end
        tick(1);
        psen_n = 0; bdata = 8'(op);
        tick(3);
        psen_n = 1;
        tick(2);
        bdata = 8'h5A;
    endtask

    task automatic strobe(bit is_wr, int len);
        if (is_wr) wr_n = 0; else rd_n = 0;
        tick(len);
        wr_n = 1; rd_n = 1;
    endtask

    initial begin
        model_reset();
        tick(4);
        rst_n = 1;
        tick(2);
        cur_req = "R1";
        spot(1'b1, "R1");

        // non-matching opcodes
        cur_req = "R2";
        foreach (hist[i]) ; // keep loop syntax simple
        fetch('hE1, 1); tick(4); spot(1'b1, "R2");
        fetch('hF1, 1); tick(4); spot(1'b1, "R2");
        fetch('hE4, 1); tick(4); spot(1'b1, "R2");
        fetch('h00, 1); tick(4); spot(1'b1, "R2");

        // each matching opcode, released by a read strobe
        cur_req = "R3";
        for (int k = 0; k < 6; k++) begin
            int ops[6] = '{'hE0, 'hE2, 'hE3, 'hF0, 'hF2, 'hF3};
            fetch(ops[k], 1);
            // psen_n released 2 negedges ago: third sampling edge is next
            spot(1'b1, "R3");
            tick(1);
            spot(1'b0, "R3");
            tick(3);
            cur_req = "R5";
            strobe(k[0], 4);
            tick(2); spot(1'b0, "R5");
            tick(1); spot(1'b1, "R5");
            tick(3);
            cur_req = "R3";
        end

        // timeout length
        cur_req = "R4";
        begin
            int low_cnt = 0;
            int waitc   = 0;
            fetch('hE2, 1);
            while (dma_ok && waitc < 10) begin tick(1); waitc++; end
            while (!dma_ok && low_cnt < 100) begin tick(1); low_cnt++; end
            compared++;
            if (low_cnt != 31) begin
                mismatched++;
                $display("FAIL R4: low cycles=%0d expected 31", low_cnt);
            end
        end
        tick(4);

        // restart of the count
        cur_req = "R6";
        fetch('hE0, 1);
        tick(20);
        fetch('hF3, 1);
        tick(25); spot(1'b0, "R6");
        tick(10); spot(1'b1, "R6");
        tick(4);

        // fetch without address-latch pulse
        cur_req = "R7";
        fetch('hF0, 0); tick(6); spot(1'b1, "R7");
        fetch('hF0, 1); tick(2); spot(1'b0, "R7");
        tick(40);

        // strobes with nothing predicted
        cur_req = "R8";
        strobe(0, 5); spot(1'b1, "R8");
        strobe(1, 5); tick(3); spot(1'b1, "R8");

        // strobe arriving near the end of the timeout, long write
        cur_req = "R5";
        fetch('hE3, 1);
        tick(26);
        strobe(1, 40);
        tick(6);
        spot(1'b1, "R5");
        tick(4);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule